// File: doc/BRIEF.md
# Flash Region CRC32 Engine

This block walks a contiguous byte region of an asynchronous parallel flash and produces the standard zip/Ethernet CRC32 of those bytes. A command carries a start address and a byte count. It is accepted over a valid/ready handshake. For each byte the engine drives the flash address and then asserts chip-enable and output-enable for two cycles. It captures the byte on the last of those cycles and folds it into a running checksum. Software can then check a large flash region by reading back one word, with no need to fetch every byte.

When the count is used up, the engine offers a 64-bit result word on a valid/ready response port. The upper half holds the address one past the last byte read. Software compares it with start plus length to confirm that the whole region was covered. The lower half holds the CRC.

Back-pressure rules:
- The response port normally feeds a FIFO, with `rsp_ready` meaning the FIFO is not full.
- While `rsp_valid` is high and `rsp_ready` is low, the word is held unchanged.
- The engine returns to idle only on the cycle both are high.
- `cmd_ready` is high only while idle, so no command can be taken while a region or its result is pending.

Top module: `flash_crc_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle; a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_valid` raised while busy has no effect on the running region or its result.
- R2: Each byte costs three cycles: one cycle with the address presented and enables low, then two cycles with `flash_ce` and `flash_oe` both high; the byte is sampled on the second enabled cycle. For N>0 bytes `rsp_valid` first rises 3N+2 cycles after the accepting edge.
- R3: The presented address starts at the command's start address, stays stable while the enables are high, and steps by exactly one after every captured byte.
- R4: The CRC is the reflected CRC32 with polynomial 0x04C11DB7 (reflected constant 0xEDB88320), equivalent to initial value 0xFFFFFFFF and final inversion; the bytes "123456789" give 0xCBF43926.
- R5: The response word carries start address plus count in bits [63:32] and the CRC in bits [31:0].
- R6: A zero-byte command performs no flash access and responds one cycle after acceptance with CRC 0x00000000 and the unchanged start address.
- R7: While `rsp_valid` is high and `rsp_ready` low, `rsp_valid` stays high and `rsp_data` is stable; after the handshake edge the engine is idle again.
- R8: An asynchronous active-low reset forces the engine idle: `cmd_ready` high, `rsp_valid`, `flash_ce` and `flash_oe` low.
- R9: The checksum is cleared when each command is accepted, so a result never depends on an earlier region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | 32 | First flash byte address |
| cmd_count | input | 32 | Number of bytes to checksum |
| flash_addr | output | 32 | Flash byte address |
| flash_ce | output | 1 | Flash chip enable, active high |
| flash_oe | output | 1 | Flash output enable, active high |
| flash_data | input | 8 | Byte returned by the flash |
| rsp_valid | output | 1 | Result word offered |
| rsp_ready | input | 1 | Consumer has room for the result |
| rsp_data | output | 64 | {end address, CRC32} |

## Verification
The bench builds the engine with its default parameters: a 32-bit address and count and a 64-bit response word. With these defaults, a zero-length request at a high address shows that the full address width passes through to the response. The flash model is 64 bytes deep and aliases higher addresses. Regions of up to 40 bytes are therefore walked, and the exhaustion of a 32-bit count lies outside what the bench reaches.

// File: rtl/flash_crc_pkg.sv
package flash_crc_pkg;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef enum logic [1:0] {
    WK_IDLE    = 2'd0,
    WK_PRESENT = 2'd1,
    WK_HOLD    = 2'd2,
    WK_CAPTURE = 2'd3
  } walk_state_t;
endpackage

// File: rtl/crc32_fold.sv
module crc32_fold
  import flash_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = CRC_POLY_R
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  // Stored value is the complemented CRC; invert in, fold LSB first, invert out.
  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = ~crc_in;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign stage[b+1] = (stage[b] >> 1) ^
                        ((stage[b][0] ^ data_in[b]) ? POLY : '0);
  end

  assign crc_out = ~stage[BYTE_W];
endmodule

// File: rtl/crc_accum.sv
module crc_accum
  import flash_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fold_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] crc_next;

  crc32_fold #(.POLY(CRC_POLY_R)) u_fold (
    .crc_in  (crc_q),
    .data_in (byte_in),
    .crc_out (crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clr)     crc_q <= '0;
    else if (fold_en) crc_q <= crc_next;
  end
endmodule

// File: rtl/flash_walker.sv
module flash_walker
  import flash_crc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce,
  output logic              flash_oe,
  input  logic [BYTE_W-1:0] flash_data,
  output logic [BYTE_W-1:0] byte_q,
  output logic              fold_en,
  output logic              crc_clr,
  output logic              rsp_valid,
  input  logic              rsp_ready
);
  walk_state_t      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              pend_q;
  logic              accept;
  logic              rsp_fire;

  assign cmd_ready  = (state_q == WK_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign crc_clr    = accept;
  assign fold_en    = (state_q == WK_PRESENT) && pend_q;
  assign rsp_valid  = (state_q == WK_PRESENT) && !pend_q && (left_q == '0);
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign flash_addr = addr_q;
  assign flash_ce   = (state_q == WK_HOLD) || (state_q == WK_CAPTURE);
  assign flash_oe   = flash_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (accept) begin
            addr_q  <= cmd_addr;
            left_q  <= cmd_count;
            pend_q  <= 1'b0;
            state_q <= WK_PRESENT;
          end
        end
        WK_PRESENT: begin
          if (pend_q) pend_q <= 1'b0;
          if (left_q != '0)  state_q <= WK_HOLD;
          else if (rsp_fire) state_q <= WK_IDLE;
        end
        WK_HOLD: state_q <= WK_CAPTURE;
        WK_CAPTURE: begin
          byte_q  <= flash_data;
          left_q  <= left_q - CNT_W'(1);
          addr_q  <= addr_q + ADDR_W'(1);
          pend_q  <= 1'b1;
          state_q <= WK_PRESENT;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_crc_engine.sv
module flash_crc_engine
  import flash_crc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned RSP_W = ADDR_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce,
  output logic              flash_oe,
  input  logic [7:0]        flash_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RSP_W-1:0]  rsp_data
);
  logic [BYTE_W-1:0] byte_q;
  logic              fold_en;
  logic              crc_clr;
  logic [CRC_W-1:0]  crc_q;

  flash_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_count  (cmd_count),
    .flash_addr (flash_addr),
    .flash_ce   (flash_ce),
    .flash_oe   (flash_oe),
    .flash_data (flash_data),
    .byte_q     (byte_q),
    .fold_en    (fold_en),
    .crc_clr    (crc_clr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready)
  );

  crc_accum u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .fold_en (fold_en),
    .byte_in (byte_q),
    .crc_q   (crc_q)
  );

  assign rsp_data = {flash_addr, crc_q};
endmodule

// File: rtl/flash_crc_engine_chk.sv
module flash_crc_engine_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RSP_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [RSP_W-1:0]  rsp_data
);
  assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_ce || rsp_valid) |-> !cmd_ready);

  assert_enable_rises_twice_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_ce) |=> flash_ce);

  assert_enable_two_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_ce && $past(flash_ce)) |=> !flash_ce);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ce |-> $stable(flash_addr));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_ce) |-> (flash_addr == $past(flash_addr) + ADDR_W'(1)));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_idle_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (cmd_ready && !rsp_valid));
endmodule

bind flash_crc_engine flash_crc_engine_chk #(.ADDR_W(ADDR_W), .RSP_W(RSP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .flash_addr (flash_addr),
  .flash_ce   (flash_ce),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data)
);

// File: tb/test_flash_crc_engine.sv
`timescale 1ns/1ps
module test_flash_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_count = '0;
  logic [31:0] flash_addr;
  logic        flash_ce, flash_oe;
  logic [7:0]  flash_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] mem [0:63];

  always #2 clk = ~clk;

  flash_crc_engine i_flash_crc_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .flash_addr(flash_addr), .flash_ce(flash_ce), .flash_oe(flash_oe),
    .flash_data(flash_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // Flash model: drives a junk value unless both enables are high.
  assign flash_data = (flash_ce && flash_oe) ? mem[flash_addr[5:0]] : 8'h5A;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] a, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, mem[(a + i) % 64]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // Runs one region; checks timing, addresses, enables, result and back-pressure.
  task automatic run_region(input logic [31:0] a, input int n, input int stall,
                            input bit poke, output logic [31:0] crc_out);
    int cyc = 1;
    int ce_cnt = 0;
    logic [63:0] held;
    logic [31:0] exp_end;
    @(negedge clk);
    cmd_addr = a; cmd_count = n; cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R1 ready when idle", cmd_ready, 1);
    @(negedge clk);
    if (poke) begin cmd_addr = a + 3; cmd_count = 1; end
    else cmd_valid = 1'b0;
    while (!rsp_valid && cyc < 1000) begin
      if (flash_ce) begin
        if (flash_addr !== a + ce_cnt / 2)
          chk(0, "R3 address sequence", flash_addr, a + ce_cnt / 2);
        if (cmd_ready !== 1'b0) chk(0, "R1 ready while busy", cmd_ready, 0);
        ce_cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(cyc == ((n == 0) ? 1 : 3 * n + 2), "R2 latency to response", cyc,
        (n == 0) ? 1 : 3 * n + 2);
    chk(ce_cnt == 2 * n, (n == 0) ? "R6 no flash access" : "R2 enable cycles",
        ce_cnt, 2 * n);
    exp_end = a + n;
    chk(rsp_data[63:32] === exp_end, "R5 end address", rsp_data[63:32], exp_end);
    chk(rsp_data[31:0] === ref_crc(a, n), "R4 crc value", rsp_data[31:0], ref_crc(a, n));
    crc_out = rsp_data[31:0];
    held = rsp_data;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_data === held, "R7 held under back-pressure",
          rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R7 idle after handshake",
        {cmd_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_reset;
    chk(cmd_ready === 1 && rsp_valid === 0 && flash_ce === 0 && flash_oe === 0,
        "R8 reset state", {cmd_ready, rsp_valid, flash_ce, flash_oe}, 4'b1000);
  endtask

  task automatic t_check_string;
    logic [31:0] c;
    run_region(32'd0, 9, 0, 0, c);
    chk(c === 32'hCBF43926, "R4 check string", c, 32'hCBF43926);
  endtask

  task automatic t_zero_len;
    logic [31:0] c;
    run_region(32'h89AB_CDE0, 0, 2, 0, c);
    chk(c === 32'h0, "R6 zero crc", c, 0);
  endtask

  task automatic t_single;
    logic [31:0] c;
    run_region(32'd20, 1, 0, 0, c);
  endtask

  task automatic t_long_stall;
    logic [31:0] c;
    run_region(32'd10, 40, 5, 0, c);
  endtask

  task automatic t_busy_poke;
    logic [31:0] c;
    run_region(32'd30, 6, 1, 1, c);
    chk(c === ref_crc(32'd30, 6), "R1 busy command ignored", c, ref_crc(32'd30, 6));
  endtask

  task automatic t_back_to_back;
    logic [31:0] c1, c2;
    run_region(32'd40, 12, 0, 0, c1);
    run_region(32'd3, 5, 0, 0, c2);
    chk(c2 === ref_crc(32'd3, 5), "R9 cleared per command", c2, ref_crc(32'd3, 5));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
    #1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_check_string();
    t_zero_len();
    t_single();
    t_long_stall();
    t_busy_poke();
    t_back_to_back();
    finish_run();
  end
endmodule